// File: doc/BRIEF.md
# Key Odd-Parity and Weak-Key Checker

This block watches a 64-bit cipher key and reports two independent kinds of trouble with it. The key is held as eight bytes. Each byte carries seven key bits and one parity bit, and the parity bit sits in the least significant position. A well-formed key has an odd number of ones in every byte. The block gives one error bit per byte and a single summary flag that can drive an indicator LED directly.

The block also flags a key that is one of four known weak keys. These are keys whose 56 effective bits, once split into halves by the key schedule, give halves that are each all zeros or all ones. The match uses only the 56 effective bits. A weak key with damaged parity bits is therefore still reported as weak.

The checker only observes the key. It does not correct the key or block it, and the cipher that uses the key keeps working when the parity is bad. All three results are registered once, so they follow the key with a latency of one clock.

Top module: `key_guard`

## Requirements
- R1: Output bit `byte_err[i]` is 1 exactly when key byte i (`key_in[8i+7:8i]`, byte 7 the most significant) holds an even number of ones. The parity bit of byte i is bit 8i.
- R2: `parity_bad` is 1 exactly when at least one bit of `byte_err` is 1.
- R3: `weak_key` is 1 when the key matches one of 0x0101010101010101, 0x1F1F1F1F0E0E0E0E, 0xE0E0E0E0F1F1F1F1 or 0xFEFEFEFEFEFEFEFE on every non-parity bit.
- R4: The values of the parity bits (bit 0 of each byte) have no effect on `weak_key`.
- R5: Every output reflects the `key_in` value sampled at the previous rising clock edge (latency of one cycle).
- R6: While `rst_n` is low at a rising edge, all outputs are cleared to 0 at that edge (synchronous, active-low reset).
- R7: A key that differs from every weak key in at least one non-parity bit gives `weak_key` = 0. A key that is weak and has bad parity raises both `weak_key` and `parity_bad`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| key_in | input | 64 | Key under test, byte 7 in bits 63:56 |
| byte_err | output | 8 | Bit i is 1 when byte i fails odd parity |
| parity_bad | output | 1 | 1 when any byte fails odd parity |
| weak_key | output | 1 | 1 when the effective key bits match a weak key |

## Verification
A wrong per-byte parity term shows up as one stuck or inverted `byte_err` bit. A single flipped key bit then toggles the wrong byte, or toggles none, and this is visible one clock after the flip. A wrong weak-key pattern or a mask that lets a parity bit through shows up as `weak_key` failing to assert, or asserting when only parity bits were changed, again one cycle after the key is applied. Because the bench model is compared at every clock, an error is caught on the first cycle in which the faulty term matters.

// File: rtl/keyguard_pkg.sv
// Shared constants, types and helpers for the key checker.
// Assumes a key of NUM_BYTES bytes with the parity bit at bit 0 of each byte.
package keyguard_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 8;
    localparam int KEY_W     = BYTE_W * NUM_BYTES;
    localparam int EFF_W     = (BYTE_W - 1) * NUM_BYTES;
    localparam int NUM_WEAK  = 4;

    typedef logic [KEY_W-1:0] key_t;
    typedef logic [EFF_W-1:0] eff_t;

    // Mask that keeps every non-parity bit of the key
    localparam key_t EFF_MASK = {NUM_BYTES{{(BYTE_W-1){1'b1}}, 1'b0}};

    // Drop the parity bit of each byte and pack the remaining bits
    function automatic eff_t strip_parity(input key_t k);
        eff_t e;
        e = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            for (int j = 1; j < BYTE_W; j++) begin
                e[b*(BYTE_W-1) + j - 1] = k[b*BYTE_W + j];
            end
        end
        return e;
    endfunction

    // Weak keys, written with their parity bits
    function automatic key_t weak_with_parity(input int idx);
        key_t k;
        case (idx)
            0:       k = 64'h0101_0101_0101_0101;
            1:       k = 64'h1F1F_1F1F_0E0E_0E0E;
            2:       k = 64'hE0E0_E0E0_F1F1_F1F1;
            default: k = 64'hFEFE_FEFE_FEFE_FEFE;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/key_byte_parity.sv
// Per-byte odd-parity test.
// Each output bit is 1 when its byte has an even count of ones.
// Assumes bytes are packed with byte 0 in the low bits.
module key_byte_parity #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 8,
    localparam int KEY_W    = BYTE_W * NUM_BYTES
) (
    input  logic [KEY_W-1:0]     key,
    output logic [NUM_BYTES-1:0] even_byte
);
    // One XNOR-reduction per byte: 1 means odd parity was violated
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        assign even_byte[g] = ~^key[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/key_weak_match.sv
// Weak-key recogniser on the effective (parity-stripped) key bits.
// Assumes the weak list in keyguard_pkg; parity bits never take part.
module key_weak_match
    import keyguard_pkg::*;
#(
    parameter int N_WEAK = NUM_WEAK
) (
    input  key_t key,
    output logic hit
);
    eff_t                     eff;
    logic [N_WEAK-1:0]        match;

    // Effective bits of the key under test
    assign eff = strip_parity(key);

    // One comparator per weak pattern
    for (genvar w = 0; w < N_WEAK; w++) begin : g_weak
        localparam eff_t PATTERN = strip_parity(weak_with_parity(w));
        assign match[w] = (eff == PATTERN);
    end

    // Any comparator hit marks the key weak
    assign hit = |match;
endmodule

// File: rtl/key_guard.sv
// Key checker top: registers per-byte parity errors, a summary flag
// and a weak-key flag one clock after the key is sampled.
// Assumes a synchronous active-low reset; the key itself is not touched.
module key_guard
    import keyguard_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [KEY_W-1:0]     key_in,
    output logic [NUM_BYTES-1:0] byte_err,
    output logic                 parity_bad,
    output logic                 weak_key
);
    logic [NUM_BYTES-1:0] err_d;
    logic                 weak_d;

    key_byte_parity #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_par (
        .key       (key_in),
        .even_byte (err_d)
    );

    key_weak_match #(
        .N_WEAK (NUM_WEAK)
    ) u_weak (
        .key (key_in),
        .hit (weak_d)
    );

    // Output register stage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_err   <= '0;
            parity_bad <= 1'b0;
            weak_key   <= 1'b0;
        end else begin
            byte_err   <= err_d;
            parity_bad <= |err_d;
            weak_key   <= weak_d;
        end
    end

    // R6
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (byte_err == '0 && !parity_bad && !weak_key));

    // R2
    summary_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (parity_bad == (byte_err != '0)));

    // R1
    single_flip_one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $countones(key_in ^ $past(key_in)) == 1)
        |=> ($countones(byte_err ^ $past(byte_err)) == 1));

    // R4
    parity_bits_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(key_in & EFF_MASK)) |=> $stable(weak_key));
endmodule

// File: tb/sim_key_guard.sv
module sim_key_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] key_in = 64'h0;
    logic [7:0]  byte_err;
    logic        parity_bad;
    logic        weak_key;

    int checks = 0;
    int errors = 0;
    string phase = "R6 reset";

    logic [7:0] exp_err;
    logic       exp_bad;
    logic       exp_weak;

    always #10 clk = ~clk;

    key_guard u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_in     (key_in),
        .byte_err   (byte_err),
        .parity_bad (parity_bad),
        .weak_key   (weak_key)
    );

    function automatic logic [7:0] ref_err(input logic [63:0] k);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            int ones = 0;
            for (int j = 0; j < 8; j++) ones += k[8*b+j];
            r[b] = (ones % 2 == 0);
        end
        return r;
    endfunction

    function automatic logic ref_weak(input logic [63:0] k);
        logic [63:0] list [4];
        list[0] = 64'h0101010101010101;
        list[1] = 64'h1F1F1F1F0E0E0E0E;
        list[2] = 64'hE0E0E0E0F1F1F1F1;
        list[3] = 64'hFEFEFEFEFEFEFEFE;
        foreach (list[i])
            if (((k ^ list[i]) & 64'hFEFEFEFEFEFEFEFE) == 64'h0) return 1'b1;
        return 1'b0;
    endfunction

    // Reference model: one-cycle registered view of the key (R5)
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_err  <= 8'h0;
            exp_bad  <= 1'b0;
            exp_weak <= 1'b0;
        end else begin
            exp_err  <= ref_err(key_in);
            exp_bad  <= (ref_err(key_in) != 8'h0);
            exp_weak <= ref_weak(key_in);
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (byte_err !== exp_err) begin
            errors++;
            $display("FAIL R1 [%s] byte_err=%02h expected %02h key=%016h", phase, byte_err, exp_err, key_in);
        end
        checks++;
        if (parity_bad !== exp_bad) begin
            errors++;
            $display("FAIL R2 [%s] parity_bad=%0b expected %0b", phase, parity_bad, exp_bad);
        end
        checks++;
        if (weak_key !== exp_weak) begin
            errors++;
            $display("FAIL R3 [%s] weak_key=%0b expected %0b", phase, weak_key, exp_weak);
        end
    end

    task automatic apply(input logic [63:0] k);
        @(negedge clk);
        key_in = k;
    endtask

    initial begin
        logic [63:0] good;
        logic [63:0] weak_list [4];
        weak_list[0] = 64'h0101010101010101;
        weak_list[1] = 64'h1F1F1F1F0E0E0E0E;
        weak_list[2] = 64'hE0E0E0E0F1F1F1F1;
        weak_list[3] = 64'hFEFEFEFEFEFEFEFE;

        // R6: bad and weak key held during reset, outputs stay 0
        key_in = 64'h0;
        repeat (4) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: known valid key, then an all-zero key (all bytes fail, weak)
        phase = "R5 latency";
        good = 64'h433E4529462A4A62;
        apply(good);
        apply(64'h0);
        apply(good);

        // R1: single-bit flip sweep over a valid key
        phase = "R1 flip sweep";
        for (int i = 0; i < 64; i++) begin
            apply(good ^ (64'h1 << i));
            apply(good);
        end

        // R3: each weak key as written
        phase = "R3 weak keys";
        foreach (weak_list[i]) apply(weak_list[i]);

        // R4: weak keys with parity bits toggled
        phase = "R4 parity bits ignored";
        foreach (weak_list[i]) begin
            apply(weak_list[i] ^ 64'h0101010101010101);
            apply(weak_list[i] ^ 64'h0000000100000100);
        end

        // R7: near misses on effective bits, and weak plus bad parity
        phase = "R7 near miss";
        foreach (weak_list[i]) begin
            for (int b = 1; b < 64; b += 9) apply(weak_list[i] ^ (64'h1 << b));
        end
        phase = "R7 weak with bad parity";
        apply(64'h0000000000000000);
        apply(64'hFFFFFFFFFFFFFFFF);

        // Mixed random keys, raw and parity-corrected
        phase = "R2 random";
        for (int n = 0; n < 300; n++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            if (n % 2 == 1) begin
                for (int b = 0; b < 8; b++)
                    r[8*b] = ~^r[8*b+1 +: 7];
            end
            apply(r);
        end

        // R6: reset asserted mid-run with a bad key
        phase = "R6 reset mid-run";
        @(negedge clk);
        rst_n = 1'b0;
        key_in = 64'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply(good);
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at check %0d", checks);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule